// File: doc/BRIEF.md
# Unary Register Dependency Column

This block is one column of a function-unit-by-register dependency matrix in a scoreboard. The column stands for a single architectural register, which the issue logic signals on its own line (one line per register, no encoded index). There is one cell per function unit. When a unit is issued, its cell records whether that unit will write the register, read it as its first operand, or read it as its second operand.

While the reservations are held, each cell guards them against a newly issued instruction on another unit. A held write reservation meets an incoming read of the register and raises a read-pending flag (read after write). A held read reservation meets an incoming write and raises a write-pending flag (write after read). When the grant logic gives a unit its go-read or go-write, the matching cell drives a register-file select for this register. The selects of all cells are ORed into one read select and one write select. The reservation is released on the next clock edge, so later instructions no longer see the hazard.

Top module: `udc_column`

## Requirements
- R1: A synchronous active-low reset clears every reservation. After reset no pending flag and no select is raised for any unit until a new issue.
- R2: On a clock edge where `issue_i[k]` is 1, cell k loads `dst_line_i`, `op1_line_i` and `op2_line_i` into its write, first-read and second-read reservations, replacing what it held.
- R3: `raw_pend_o[k]` is 1 when cell k holds a write reservation, `issue_i[k]` is 0, some other bit of `issue_i` is 1, and `op1_line_i` or `op2_line_i` is 1.
- R4: `war_pend_o[k]` is 1 when cell k holds either read reservation, `issue_i[k]` is 0, some other bit of `issue_i` is 1, and `dst_line_i` is 1.
- R5: No pending flag is raised for a unit whose own issue bit is 1, and none is raised in a cycle where `issue_i` is all zero.
- R6: `wr_sel_o` is 1 in the same cycle when some cell k holds a write reservation with `go_wr_i[k]` = 1 and `issue_i[k]` = 0. Otherwise it is 0.
- R7: `rd_sel_o` is 1 in the same cycle when some cell k holds either read reservation with `go_rd_i[k]` = 1 and `issue_i[k]` = 0. Otherwise it is 0.
- R8: On the edge that ends a cycle in which `go_wr_i[k]` = 1 and `issue_i[k]` = 0, cell k drops its write reservation. On the edge that ends a cycle in which `go_rd_i[k]` = 1 and `issue_i[k]` = 0, cell k drops both read reservations.
- R9: When `issue_i[k]` and a go bit for unit k are 1 in the same cycle, the issue wins. That go bit produces no select, and the reservations loaded by the issue stay held afterwards.
- R10: A cell with neither its issue bit nor a matching go bit keeps its reservations unchanged, including a go of the other kind. Go-write leaves the read reservations alone, and go-read leaves the write reservation alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_i | input | NUM_FU | Issue strobe, one bit per function unit |
| dst_line_i | input | 1 | Issuing instruction writes this register |
| op1_line_i | input | 1 | Issuing instruction reads this register as first operand |
| op2_line_i | input | 1 | Issuing instruction reads this register as second operand |
| go_rd_i | input | NUM_FU | Go-read grant, one bit per function unit |
| go_wr_i | input | NUM_FU | Go-write grant, one bit per function unit |
| raw_pend_o | output | NUM_FU | Read-after-write pending, per unit |
| war_pend_o | output | NUM_FU | Write-after-read pending, per unit |
| rd_sel_o | output | 1 | Register-file read select for this register |
| wr_sel_o | output | 1 | Register-file write select for this register |

## Verification
The bench targets these corner cases:
- Issue and go for the same unit in one cycle. A design that let the go through would flash a select and lose the new reservation.
- A go of the wrong kind. A design that cleared on any go would drop a write reservation on a go-read, or the reverse.
- A unit's own issue against its own held reservation. If this raised a pending flag, the unit would block itself.
- A second select on the cycle after a go. If the release came late, the select would repeat. If it came early, no select would be seen at all.

Random one-hot issue and grant traffic then runs against a reference model kept in the bench.

// File: rtl/udc_pkg.sv
// Package: shared types for the unary dependency column.
// Assumes: nothing beyond the standard types.
package udc_pkg;

    // Reservation bits held by one cell.
    typedef struct packed {
        logic wr;   // unit will write this register
        logic rd1;  // unit reads it as first operand
        logic rd2;  // unit reads it as second operand
    } resv_t;

endpackage

// File: rtl/udc_cell.sv
// Module: one dependency cell (one function unit, one register).
// Holds three reservation flops. It raises hazards against another unit's
// issue and drives select requests on go grants.
// Assumes: issue and go arrive registered from the picker; issue wins over go.
module udc_cell
    import udc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  issue,
    input  logic  any_issue,
    input  logic  dst_line,
    input  logic  op1_line,
    input  logic  op2_line,
    input  logic  go_rd,
    input  logic  go_wr,
    output resv_t resv,
    output logic  raw_pend,
    output logic  war_pend,
    output logic  rd_req,
    output logic  wr_req
);

    resv_t resv_q;
    logic  go_rd_eff;
    logic  go_wr_eff;
    logic  foreign_issue;

    // Go grants count only when this unit is not being issued.
    always_comb begin
        go_rd_eff = go_rd & ~issue;
        go_wr_eff = go_wr & ~issue;
    end

    // Reservation update: reset, capture on issue, release on go.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resv_q <= '0;
        end else if (issue) begin
            resv_q.wr  <= dst_line;
            resv_q.rd1 <= op1_line;
            resv_q.rd2 <= op2_line;
        end else begin
            if (go_wr_eff) resv_q.wr <= 1'b0;
            if (go_rd_eff) begin
                resv_q.rd1 <= 1'b0;
                resv_q.rd2 <= 1'b0;
            end
        end
    end

    // Hazard flags against an instruction issuing on some other unit.
    always_comb begin
        foreign_issue = any_issue & ~issue;
        raw_pend      = foreign_issue & resv_q.wr & (op1_line | op2_line);
        war_pend      = foreign_issue & (resv_q.rd1 | resv_q.rd2) & dst_line;
    end

    // Select requests formed from held reservations and effective grants.
    always_comb begin
        rd_req = (resv_q.rd1 | resv_q.rd2) & go_rd_eff;
        wr_req = resv_q.wr & go_wr_eff;
    end

    assign resv = resv_q;

endmodule

// File: rtl/udc_or_reduce.sv
// Module: OR reduction of per-unit select requests into one column select.
// Assumes: at most one requester at a time (the picker guarantees this);
// the OR stays correct for any count.
module udc_or_reduce #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] req,
    output logic             any
);

    // Plain reduction; the tool balances the tree.
    always_comb any = |req;

endmodule

// File: rtl/udc_column.sv
// Module: top of one register column of the dependency matrix.
// One cell per function unit. The per-unit hazard flags and the ORed
// register-file selects are the outputs.
// Assumes: registers are signalled on unary lines, and the picker raises at
// most one go-read and one go-write bit per cycle.
module udc_column
    import udc_pkg::*;
#(
    parameter int NUM_FU = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_FU-1:0] issue_i,
    input  logic              dst_line_i,
    input  logic              op1_line_i,
    input  logic              op2_line_i,
    input  logic [NUM_FU-1:0] go_rd_i,
    input  logic [NUM_FU-1:0] go_wr_i,
    output logic [NUM_FU-1:0] raw_pend_o,
    output logic [NUM_FU-1:0] war_pend_o,
    output logic              rd_sel_o,
    output logic              wr_sel_o
);

    localparam int FU_LAST = NUM_FU - 1;

    logic              any_issue;
    logic [NUM_FU-1:0] rd_req;
    logic [NUM_FU-1:0] wr_req;
    logic [NUM_FU-1:0] dest_q;
    logic [NUM_FU-1:0] src1_q;
    logic [NUM_FU-1:0] src2_q;

    // Flags whether any unit issues this cycle.
    always_comb any_issue = |issue_i;

    // One cell per function unit.
    for (genvar k = 0; k <= FU_LAST; k++) begin : g_cell
        resv_t resv_k;
        udc_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .issue     (issue_i[k]),
            .any_issue (any_issue),
            .dst_line  (dst_line_i),
            .op1_line  (op1_line_i),
            .op2_line  (op2_line_i),
            .go_rd     (go_rd_i[k]),
            .go_wr     (go_wr_i[k]),
            .resv      (resv_k),
            .raw_pend  (raw_pend_o[k]),
            .war_pend  (war_pend_o[k]),
            .rd_req    (rd_req[k]),
            .wr_req    (wr_req[k])
        );
        // Flatten reservation state for the checker.
        always_comb begin
            dest_q[k] = resv_k.wr;
            src1_q[k] = resv_k.rd1;
            src2_q[k] = resv_k.rd2;
        end
    end

    // Column-wide read select.
    udc_or_reduce #(.WIDTH(NUM_FU)) u_rd_or (.req(rd_req), .any(rd_sel_o));

    // Column-wide write select.
    udc_or_reduce #(.WIDTH(NUM_FU)) u_wr_or (.req(wr_req), .any(wr_sel_o));

endmodule

// File: rtl/udc_column_chk.sv
// Module: assertion checker for udc_column, attached by bind.
// Assumes: it sees the top's ports and its flattened reservation vectors.
module udc_column_chk #(
    parameter int NUM_FU = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_FU-1:0] issue_i,
    input logic              dst_line_i,
    input logic              op1_line_i,
    input logic              op2_line_i,
    input logic [NUM_FU-1:0] go_rd_i,
    input logic [NUM_FU-1:0] go_wr_i,
    input logic [NUM_FU-1:0] raw_pend_o,
    input logic [NUM_FU-1:0] war_pend_o,
    input logic              rd_sel_o,
    input logic              wr_sel_o,
    input logic [NUM_FU-1:0] dest_q,
    input logic [NUM_FU-1:0] src1_q,
    input logic [NUM_FU-1:0] src2_q
);

    for (genvar k = 0; k < NUM_FU; k++) begin : g_chk
        // R2: an issue loads all three lines.
        a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
            issue_i[k] |=> (dest_q[k] == $past(dst_line_i)) &&
                           (src1_q[k] == $past(op1_line_i)) &&
                           (src2_q[k] == $past(op2_line_i)));
        // R3: a read-after-write flag needs a read line on the issue.
        a_r3_raw_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
            raw_pend_o[k] |-> (op1_line_i || op2_line_i) && dest_q[k]);
        // R4: a write-after-read flag needs the write line.
        a_r4_war_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
            war_pend_o[k] |-> dst_line_i && (src1_q[k] || src2_q[k]));
        // R5: a unit never flags against its own issue.
        a_r5_no_self_hazard: assert property (@(posedge clk) disable iff (!rst_n)
            issue_i[k] |-> !raw_pend_o[k] && !war_pend_o[k]);
        // R8: a serviced go-write drops the write reservation.
        a_r8_wr_release: assert property (@(posedge clk) disable iff (!rst_n)
            (go_wr_i[k] && !issue_i[k]) |=> !dest_q[k]);
        // R8: a serviced go-read drops both read reservations.
        a_r8_rd_release: assert property (@(posedge clk) disable iff (!rst_n)
            (go_rd_i[k] && !issue_i[k]) |=> !src1_q[k] && !src2_q[k]);
        // R10: with no issue and no go-write, the write reservation holds.
        a_r10_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!issue_i[k] && !go_wr_i[k]) |=> $stable(dest_q[k]));
        // R10: with no issue and no go-read, the read reservations hold.
        a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!issue_i[k] && !go_rd_i[k]) |=> $stable(src1_q[k]) && $stable(src2_q[k]));
    end

    // R6: a write select needs a go-write on a unit not being issued.
    a_r6_wr_sel_grant: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel_o |-> |(go_wr_i & ~issue_i & dest_q));
    // R7: a read select needs a go-read on a unit not being issued.
    a_r7_rd_sel_grant: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel_o |-> |(go_rd_i & ~issue_i & (src1_q | src2_q)));
    // R5: no issue means no hazard flag anywhere.
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i == '0) |-> (raw_pend_o == '0) && (war_pend_o == '0));

endmodule

bind udc_column udc_column_chk #(.NUM_FU(NUM_FU)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_i    (issue_i),
    .dst_line_i (dst_line_i),
    .op1_line_i (op1_line_i),
    .op2_line_i (op2_line_i),
    .go_rd_i    (go_rd_i),
    .go_wr_i    (go_wr_i),
    .raw_pend_o (raw_pend_o),
    .war_pend_o (war_pend_o),
    .rd_sel_o   (rd_sel_o),
    .wr_sel_o   (wr_sel_o),
    .dest_q     (dest_q),
    .src1_q     (src1_q),
    .src2_q     (src2_q)
);

// File: tb/udc_column_bench.sv
// Bench: directed corner cases, then seeded random traffic, against a model.
module udc_column_bench;

    localparam int NFU    = 4;
    localparam int CLK_NS = 10;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NFU-1:0] issue_i;
    logic           dst_line_i, op1_line_i, op2_line_i;
    logic [NFU-1:0] go_rd_i, go_wr_i;
    logic [NFU-1:0] raw_pend_o, war_pend_o;
    logic           rd_sel_o, wr_sel_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    logic [NFU-1:0] m_wr, m_rd1, m_rd2;

    always #(CLK_NS/2) clk = ~clk;

    udc_column #(.NUM_FU(NFU)) u_udc_column (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i),
        .dst_line_i(dst_line_i), .op1_line_i(op1_line_i), .op2_line_i(op2_line_i),
        .go_rd_i(go_rd_i), .go_wr_i(go_wr_i),
        .raw_pend_o(raw_pend_o), .war_pend_o(war_pend_o),
        .rd_sel_o(rd_sel_o), .wr_sel_o(wr_sel_o)
    );

    // Expected read-after-write flags (R3, R5).
    function automatic logic [NFU-1:0] exp_raw();
        logic [NFU-1:0] r = '0;
        for (int k = 0; k < NFU; k++)
            r[k] = m_wr[k] && !issue_i[k] && (|issue_i) && (op1_line_i || op2_line_i);
        return r;
    endfunction

    // Expected write-after-read flags (R4, R5).
    function automatic logic [NFU-1:0] exp_war();
        logic [NFU-1:0] r = '0;
        for (int k = 0; k < NFU; k++)
            r[k] = (m_rd1[k] || m_rd2[k]) && !issue_i[k] && (|issue_i) && dst_line_i;
        return r;
    endfunction

    // Expected write select (R6, R9).
    function automatic logic exp_wsel();
        logic r = 1'b0;
        for (int k = 0; k < NFU; k++) r |= m_wr[k] && go_wr_i[k] && !issue_i[k];
        return r;
    endfunction

    // Expected read select (R7, R9).
    function automatic logic exp_rsel();
        logic r = 1'b0;
        for (int k = 0; k < NFU; k++) r |= (m_rd1[k] || m_rd2[k]) && go_rd_i[k] && !issue_i[k];
        return r;
    endfunction

    task automatic check(input string tag, input logic [NFU-1:0] act, input logic [NFU-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check mid-cycle, then update the model.
    task automatic step(input logic [NFU-1:0] iss, input logic d, input logic s1, input logic s2,
                        input logic [NFU-1:0] gr, input logic [NFU-1:0] gw, input string tag);
        @(negedge clk);
        issue_i = iss; dst_line_i = d; op1_line_i = s1; op2_line_i = s2;
        go_rd_i = gr; go_wr_i = gw;
        #1;
        check({tag, " R3 raw"}, raw_pend_o, exp_raw());
        check({tag, " R4 war"}, war_pend_o, exp_war());
        check({tag, " R7 rdsel"}, {{(NFU-1){1'b0}}, rd_sel_o}, {{(NFU-1){1'b0}}, exp_rsel()});
        check({tag, " R6 wrsel"}, {{(NFU-1){1'b0}}, wr_sel_o}, {{(NFU-1){1'b0}}, exp_wsel()});
        @(posedge clk);
        for (int k = 0; k < NFU; k++) begin
            if (iss[k]) begin
                m_wr[k] = d; m_rd1[k] = s1; m_rd2[k] = s2;
            end else begin
                if (gw[k]) m_wr[k] = 1'b0;
                if (gr[k]) begin m_rd1[k] = 1'b0; m_rd2[k] = 1'b0; end
            end
        end
    endtask

    function automatic logic [NFU-1:0] pick_onehot();
        int v = $urandom % (2 * NFU);
        return (v < NFU) ? (NFU'(1) << v) : '0;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_NS * 150000);
        if (!finished) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        rst_n = 1'b0; issue_i = '0; dst_line_i = 0; op1_line_i = 0; op2_line_i = 0;
        go_rd_i = '0; go_wr_i = '0;
        m_wr = '0; m_rd1 = '0; m_rd2 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: after reset nothing is held, even with every line and grant up.
        step(4'b0001, 1, 1, 1, 4'b1110, 4'b1110, "R1 reset");
        // R2: unit 0 now holds all three; unit 1 issue reading the register.
        step(4'b0010, 0, 1, 0, 4'b0000, 4'b0000, "R2 capture");
        // R5: unit 0 re-issue does not flag itself; R2 replace with write only.
        step(4'b0001, 1, 0, 0, 4'b0000, 4'b0000, "R5 self");
        // R5: no issue, no flags.
        step(4'b0000, 1, 1, 1, 4'b0000, 4'b0000, "R5 idle");
        // R10: go-read to unit 0 (no read held now) leaves its write held.
        step(4'b0000, 0, 0, 0, 4'b0001, 4'b0000, "R10 wrong go");
        step(4'b0100, 0, 0, 1, 4'b0000, 4'b0000, "R10 still held");
        // R9: issue and go-write to unit 0 together: no select, new write kept.
        step(4'b0001, 1, 0, 0, 4'b0000, 4'b0001, "R9 priority");
        step(4'b0000, 0, 0, 0, 4'b0000, 4'b0001, "R9 kept R6 select");
        // R8: write released the cycle after its select.
        step(4'b0000, 0, 0, 0, 4'b0000, 4'b0001, "R8 wr released");
        // R8: unit 1 read release (unit 1 holds op1 from above).
        step(4'b0000, 0, 0, 0, 4'b0010, 4'b0000, "R7 select");
        step(4'b0000, 0, 0, 0, 4'b0010, 4'b0000, "R8 rd released");
        step(4'b1000, 1, 0, 0, 4'b0000, 4'b0000, "R8 no war after release");

        // Random traffic.
        for (int n = 0; n < 4000; n++) begin
            logic [NFU-1:0] iss, gr, gw;
            iss = pick_onehot(); gr = pick_onehot(); gw = pick_onehot();
            step(iss, 1'($urandom), 1'($urandom), 1'($urandom), gr, gw, "rand");
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule